// File: doc/BRIEF.md
# Synthesizer Power-Up Programming Sequencer

This controller loads a serially configured PLL frequency synthesizer over a three-wire link made of a serial clock, serial data and a latch-enable strobe. On a start request it captures three parallel words: a reference-divider word, a control word and a feedback-divider word. It shifts them out one after another, MSB first, and gives each word its own latch-enable strobe.

The synthesizer needs time for its oscillator bias to settle after the control word powers it up. For that reason, the first programming after reset adds a counted wait between the control word and the feedback-divider word. A request marked as an initial power-up also adds this wait. A later plain reprogram sends the three words back to back. A one-bit input selects the wait length, long or short, to match the size of the noise-filter capacitor on the board. Both lengths are computed by default from the system clock frequency. `busy` covers the whole sequence. `done` pulses once when the third strobe ends.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset, `sclk`, `le`, `busy` and `done` are all low.
- R2: Each sequence sends exactly three words of WORD_W (24) bits each. The order is reference word, then control word, then feedback word. Each word goes MSB first and is read on the rising edges of `sclk`.
- R3: `sdata` changes only while `sclk` is low, so it is stable whenever `sclk` is high.
- R4: `le` stays low while a word shifts. After the last bit it is high for at least 2*SCLK_HALF system cycles, which is one serial clock period, and `sclk` is low the whole time `le` is high.
- R5: The first sequence after reset inserts a settling wait of at least the selected length. This applies even when it is started by `start_reprog`. The wait is measured from the fall of the second `le` to the first `sclk` rise of the third word.
- R6: A sequence started by `start_init` always inserts the settling wait.
- R7: A sequence started by `start_reprog` after a completed sequence inserts no wait. The third word's first `sclk` rise follows the second `le` fall within 2*SCLK_HALF+4 cycles.
- R8: The words are captured when the sequence starts. Start requests and word changes while `busy` is high have no effect on the words sent.
- R9: `done` is high for exactly one cycle, on the cycle the third `le` falls, and `busy` is low while `done` is high.
- R10: `cap_sel`=1 selects a wait of SYS_HZ/100 cycles (10 ms). `cap_sel`=0 selects (SYS_HZ/10000)*6 cycles (600 us). `cap_sel` is sampled when the sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_init | input | 1 | Request a power-up sequence with settling wait |
| start_reprog | input | 1 | Request a reprogram sequence |
| cap_sel | input | 1 | 1: long wait, 0: short wait |
| ref_word | input | WORD_W | Reference-divider word, sent first |
| ctl_word | input | WORD_W | Control word, sent second |
| fb_word | input | WORD_W | Feedback-divider word, sent third |
| sclk | output | 1 | Serial clock |
| sdata | output | 1 | Serial data |
| le | output | 1 | Latch-enable strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong word index or a bad shift count shows up at the end of a sequence. The bench would see a word out of order, a fourth strobe, or a word of the wrong length. A stuck power-up flag shows up one sequence later, when a plain reprogram arrives with a wait of hundreds of cycles between its second and third strobes. A cleared flag shows up on the first sequence after reset, as a missing wait. Divider-phase errors break the hold of data under a high `sclk` or let `sclk` rise during a strobe, and these are visible within a single bit period.

// File: rtl/synth_prog_seq.sv
module synth_prog_seq #(
  parameter int WORD_W     = 24,
  parameter int SCLK_HALF  = 4,
  parameter int SYS_HZ     = 250_000_000,
  parameter int WAIT_LONG  = SYS_HZ / 100,
  parameter int WAIT_SHORT = (SYS_HZ / 10000) * 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_init,
  input  logic              start_reprog,
  input  logic              cap_sel,
  input  logic [WORD_W-1:0] ref_word,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [WORD_W-1:0] fb_word,
  output logic              sclk,
  output logic              sdata,
  output logic              le,
  output logic              busy,
  output logic              done
);
  localparam int CW = $clog2(WAIT_LONG + 4 * SCLK_HALF + 2);
  localparam int BW = $clog2(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LATCH, S_WAIT} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bitn;
  logic [1:0]       widx;
  logic [WORD_W-1:0] sr, ctl_q, fb_q;
  logic             wait_q, long_q, first_q;

  wire start    = start_init | start_reprog;
  wire half_end = (cnt == CW'(SCLK_HALF - 1));
  wire le_end   = (cnt == CW'(2 * SCLK_HALF - 1));
  wire [CW-1:0] wait_last = long_q ? CW'(WAIT_LONG - 1) : CW'(WAIT_SHORT - 1);

  assign sdata = sr[WORD_W-1];
  assign busy  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      widx    <= '0;
      sr      <= '0;
      ctl_q   <= '0;
      fb_q    <= '0;
      wait_q  <= 1'b0;
      long_q  <= 1'b0;
      first_q <= 1'b1;
      sclk    <= 1'b0;
      le      <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SHIFT;
          sr     <= ref_word;
          ctl_q  <= ctl_word;
          fb_q   <= fb_word;
          wait_q <= start_init | first_q;
          long_q <= cap_sel;
          widx   <= 2'd0;
          bitn   <= BW'(WORD_W - 1);
          cnt    <= '0;
          sclk   <= 1'b0;
        end
        S_SHIFT: if (half_end) begin
          cnt <= '0;
          if (!sclk) sclk <= 1'b1;
          else begin
            sclk <= 1'b0;
            if (bitn == '0) begin
              st <= S_LATCH;
              le <= 1'b1;
            end else begin
              bitn <= bitn - 1'b1;
              sr   <= {sr[WORD_W-2:0], 1'b0};
            end
          end
        end else cnt <= cnt + 1'b1;
        S_LATCH: if (le_end) begin
          cnt  <= '0;
          le   <= 1'b0;
          bitn <= BW'(WORD_W - 1);
          case (widx)
            2'd0: begin
              sr   <= ctl_q;
              widx <= 2'd1;
              st   <= S_SHIFT;
            end
            2'd1: begin
              widx <= 2'd2;
              if (wait_q) st <= S_WAIT;
              else begin
                sr <= fb_q;
                st <= S_SHIFT;
              end
            end
            default: begin
              st      <= S_IDLE;
              done    <= 1'b1;
              first_q <= 1'b0;
            end
          endcase
        end else cnt <= cnt + 1'b1;
        S_WAIT: if (cnt == wait_last) begin
          cnt <= '0;
          sr  <= fb_q;
          st  <= S_SHIFT;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_LE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) le |-> !sclk);  // R4
  AST_DATA_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(sdata));  // R3
  AST_DONE_ONE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);  // R9
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);  // R9
  AST_START_IGN:   assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(fb_q) && $stable(ctl_q));  // R8
endmodule

// File: tb/synth_prog_seq_tb.sv
`timescale 1ns/1ps
module synth_prog_seq_tb_top;
  localparam int W      = 24;
  localparam int HALF   = 2;
  localparam int SYSHZ  = 100_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_init = 0, start_reprog = 0, cap_sel = 0;
  logic [W-1:0] ref_word = '0, ctl_word = '0, fb_word = '0;
  logic sclk, sdata, le, busy, done;

  always #2 clk = ~clk;

  synth_prog_seq #(.WORD_W(W), .SCLK_HALF(HALF), .SYS_HZ(SYSHZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_init(start_init), .start_reprog(start_reprog),
    .cap_sel(cap_sel), .ref_word(ref_word), .ctl_word(ctl_word), .fb_word(fb_word),
    .sclk(sclk), .sdata(sdata), .le(le), .busy(busy), .done(done));

  int tests = 0, fails = 0;
  bit finished = 0;

  // monitor state, written only by the monitor
  int cyc = 0, nw = 0, ndone = 0, gap3 = -1, le_fall = 0, le_w = 0;
  int viol_d = 0, viol_le = 0, viol_done = 0;
  bit armed = 0, psclk = 0, ple = 0, psdata = 0, pdone = 0;
  logic [W-1:0] shreg = '0;
  logic [W-1:0] got [0:7];

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      psclk = 0; ple = 0; pdone = 0; armed = 0; le_w = 0;
    end else begin
      if (sclk && !psclk) begin
        shreg = {shreg[W-2:0], sdata};
        if (armed) begin
          if (nw % 3 == 2) gap3 = cyc - le_fall;
          armed = 0;
        end
      end
      if (sclk && psclk && sdata != psdata) viol_d++;
      if (le && sclk) viol_le++;
      if (le && !ple) begin
        got[nw % 8] = shreg;
        nw++;
        le_w = 0;
      end
      if (le) le_w++;
      if (!le && ple) begin
        le_fall = cyc;
        armed = 1;
        if (le_w < 2 * HALF) viol_le++;
      end
      if (done) begin
        ndone++;
        if (busy || pdone) viol_done++;
      end
      psclk = sclk; ple = le; psdata = sdata; pdone = done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_wait(input bit cs);
    return cs ? SYSHZ / 100 : (SYSHZ / 10000) * 6;
  endfunction

  task automatic run(input bit init, input bit cs, input bit want_wait, input bit poke,
                     input string wreq);
    logic [W-1:0] r, c, f;
    int nw0, nd0, vd0, vl0, vn0, base, w;
    r = W'($urandom); c = W'($urandom); f = W'($urandom);
    nw0 = nw; nd0 = ndone; vd0 = viol_d; vl0 = viol_le; vn0 = viol_done;
    @(negedge clk);
    ref_word = r; ctl_word = c; fb_word = f; cap_sel = cs;
    start_init = init; start_reprog = !init;
    @(negedge clk);
    start_init = 0; start_reprog = 0;
    ref_word = ~r; ctl_word = W'($urandom); fb_word = ~f; cap_sel = !cs;
    if (poke) begin
      repeat (20 + ($urandom % 200)) @(negedge clk);
      start_reprog = 1; start_init = $urandom % 2;
      @(negedge clk);
      start_reprog = 0; start_init = 0;
    end
    for (int k = 0; k < 20000 && ndone == nd0; k++) @(negedge clk);
    repeat (12) @(negedge clk);
    chk(ndone - nd0 == 1, "R9", "done pulses", ndone - nd0, 1);
    chk(viol_done == vn0, "R9", "done width/busy violations", viol_done - vn0, 0);
    chk(nw - nw0 == 3, "R8", "words per sequence", nw - nw0, 3);
    base = nw0 % 8;
    chk(got[base] == r, "R2", "first word (reference)", got[base], r);
    chk(got[(base + 1) % 8] == c, "R2", "second word (control)", got[(base + 1) % 8], c);
    chk(got[(base + 2) % 8] == f, "R2", "third word (feedback)", got[(base + 2) % 8], f);
    chk(viol_d == vd0, "R3", "data changes with sclk high", viol_d - vd0, 0);
    chk(viol_le == vl0, "R4", "strobe width/sclk violations", viol_le - vl0, 0);
    if (want_wait) begin
      w = exp_wait(cs);
      chk(gap3 >= w && gap3 <= w + 2 * HALF + 4, wreq, "settling gap (R10 length)", gap3, w);
    end else
      chk(gap3 >= 0 && gap3 <= 2 * HALF + 4, wreq, "no-wait gap", gap3, 2 * HALF + 4);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(sclk == 0 && le == 0, "R1", "sclk/le after reset", {sclk, le}, 0);
    chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(sclk == 0 && le == 0 && busy == 0, "R1", "idle after release", {sclk, le, busy}, 0);
    run(0, 0, 1, 0, "R5");      // first after reset via reprog: short wait
    run(0, 1, 0, 0, "R7");      // later reprog: no wait
    run(1, 1, 1, 1, "R6");      // init request: long wait, busy poke
    run(1, 0, 1, 0, "R6");
    for (int i = 0; i < 6; i++) begin
      bit ini, cs;
      ini = $urandom % 2; cs = $urandom % 2;
      run(ini, cs, ini, 1, ini ? "R6" : "R7");
    end
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(sclk == 0 && le == 0 && busy == 0, "R1", "second reset", {sclk, le, busy}, 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 1, 1, 1, "R5");      // flag set again after reset: long wait
    run(0, 0, 0, 0, "R7");
    finish_up();
  end
endmodule